// File: doc/BRIEF.md
# Reference Power-Up Sequencer

This block manages the power of a converter's internal voltage reference around each conversion. A small control register selects internal or external reference, whether the internal reference is switched off between conversions, a 2-bit settling-time code and the reference voltage. When a conversion is requested, the block decides whether the internal reference must be powered up. It also decides whether a settling wait must pass before the converter may start. It then issues a single-cycle start pulse.

A settling wait is inserted only when the internal reference is in use and is switched off between conversions. In that case the reference enable rises with the request. The wait is counted in microsecond ticks derived from the clock by a prescaler. The converter reports completion with a done input, after which a power-down-between-conversions reference is switched off again. External mode keeps the internal reference off under all conditions.

Top module: `refpwr_sequencer`

## Requirements
- R1: The control register resets to 6'b000010. Bit 0 selects the mode (1 = internal reference). Bit 1 powers the reference down between conversions. Bit 2 selects the voltage. Bits 4:3 hold the settling code. Bit 5 is reserved, always reads 0 and ignores writes. A write is visible on `cfg_rdata` the cycle after it is sampled.
- R2: With bit 0 at 0 (external), `ref_en` stays low at all times, including during a conversion.
- R3: With internal mode and bit 1 at 0, `ref_en` is high at all times, from two cycles after the write onward.
- R4: With internal mode and bit 1 at 1, `ref_en` rises in the cycle after a request is accepted, stays high until `conv_done` is sampled during a conversion, and is low in the cycle after that.
- R5: With internal mode and bit 1 at 1, settling codes 0, 1, 2 and 3 give a wait of 0, DLY1_US, DLY2_US or DLY3_US microseconds, one microsecond being CLKS_PER_US clocks. `conv_start` is high in the cycle that follows the edge that is wait × CLKS_PER_US clocks after the edge that sampled the request.
- R6: In every other configuration, `conv_start` is high in the cycle right after the request is sampled.
- R7: `conv_start` is high for exactly one cycle. `busy` is high from the cycle after an accepted request until the cycle after `conv_done` is sampled during the conversion.
- R8: `conv_req` while `busy` is high is ignored. `conv_done` while idle is ignored.
- R9: `ref_vsel` follows bit 2 of the control register (0 = low voltage, 1 = high voltage) in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write data |
| cfg_rdata | output | 6 | Control register contents |
| conv_req | input | 1 | Conversion request |
| conv_done | input | 1 | Conversion finished |
| ref_en | output | 1 | Internal reference power enable |
| ref_vsel | output | 1 | Reference voltage select |
| conv_start | output | 1 | One-cycle conversion start |
| busy | output | 1 | Settling wait or conversion in progress |

## Verification
A wrong settling count or prescaler value moves the `conv_start` pulse by a whole number of clocks. This shows on the first request of the affected configuration. A stuck state shows as `busy` failing to clear in the cycle after `conv_done`, or as a second start pulse after a request made while busy. A wrong power decision shows on `ref_en` within two cycles of a configuration write or of a request.

// File: rtl/refpwr_pkg.sv
package refpwr_pkg;

  typedef struct packed {
    logic       rsvd;
    logic [1:0] dly;
    logic       vsel;
    logic       pdn;
    logic       intm;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{rsvd: 1'b0, dly: 2'b00, vsel: 1'b0, pdn: 1'b1, intm: 1'b0};

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/refpwr_cfg_reg.sv
module refpwr_cfg_reg
  import refpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [5:0] wdata,
  output cfg_t       cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (we) begin
      cfg <= cfg_t'({1'b0, wdata[4:0]});
    end
  end

endmodule

// File: rtl/refpwr_settle_timer.sv
module refpwr_settle_timer #(
  parameter int CLKS_PER_US = 4,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_us,
  input  logic             run,
  output logic             last
);

  logic             us_tick;
  logic [CNT_W-1:0] rem_q;

  generate
    if (CLKS_PER_US == 1) begin : g_no_pre
      assign us_tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CLKS_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || load) begin
          pre_q <= '0;
        end else if (run) begin
          pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
      end

      assign us_tick = (pre_q == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_us;
    end else if (run && us_tick) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last = run && us_tick && (rem_q == CNT_W'(1));

endmodule

// File: rtl/refpwr_seq_fsm.sv
module refpwr_seq_fsm
  import refpwr_pkg::*;
#(
  parameter int DLY1_US = 100,
  parameter int DLY2_US = 500,
  parameter int DLY3_US = 1000,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic             conv_req,
  input  logic             conv_done,
  input  logic             timer_last,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_us,
  output logic             timer_run,
  output logic             ref_en,
  output logic             conv_start,
  output logic             busy
);

  seq_state_t state_q, state_d;
  logic       delay_on;
  logic       start_d;

  always_comb begin
    case (cfg.dly)
      2'd1:    timer_us = CNT_W'(DLY1_US);
      2'd2:    timer_us = CNT_W'(DLY2_US);
      2'd3:    timer_us = CNT_W'(DLY3_US);
      default: timer_us = '0;
    endcase
  end

  assign delay_on = cfg.intm && cfg.pdn && (cfg.dly != 2'd0);

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    start_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (conv_req) begin
          if (delay_on) begin
            timer_load = 1'b1;
            state_d    = ST_SETTLE;
          end else begin
            start_d = 1'b1;
            state_d = ST_CONV;
          end
        end
      end
      ST_SETTLE: begin
        if (timer_last) begin
          start_d = 1'b1;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (conv_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign timer_run = (state_q == ST_SETTLE);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      conv_start <= 1'b0;
      ref_en     <= 1'b0;
    end else begin
      state_q    <= state_d;
      conv_start <= start_d;
      ref_en     <= cfg.intm && (!cfg.pdn || (state_d != ST_IDLE));
    end
  end

endmodule

// File: rtl/refpwr_sequencer.sv
module refpwr_sequencer
  import refpwr_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int DLY1_US     = 100,
  parameter int DLY2_US     = 500,
  parameter int DLY3_US     = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] cfg_rdata,
  input  logic       conv_req,
  input  logic       conv_done,
  output logic       ref_en,
  output logic       ref_vsel,
  output logic       conv_start,
  output logic       busy
);

  localparam int CNT_W = $clog2(DLY3_US + 1);

  cfg_t             cfg;
  logic             timer_load;
  logic             timer_run;
  logic             timer_last;
  logic [CNT_W-1:0] timer_us;

  refpwr_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  refpwr_settle_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .load_us (timer_us),
    .run     (timer_run),
    .last    (timer_last)
  );

  refpwr_seq_fsm #(
    .DLY1_US (DLY1_US),
    .DLY2_US (DLY2_US),
    .DLY3_US (DLY3_US),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .timer_last (timer_last),
    .timer_load (timer_load),
    .timer_us   (timer_us),
    .timer_run  (timer_run),
    .ref_en     (ref_en),
    .conv_start (conv_start),
    .busy       (busy)
  );

  assign cfg_rdata = cfg;
  assign ref_vsel  = cfg.vsel;

endmodule

// File: rtl/refpwr_checker.sv
module refpwr_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] cfg_rdata,
  input logic       conv_req,
  input logic       conv_done,
  input logic       ref_en,
  input logic       conv_start,
  input logic       busy
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (cfg_rdata[5] == 1'b0));

  assert_ext_off_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !cfg_rdata[0] && !$past(cfg_rdata[0])) |-> !ref_en);

  assert_pwr_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && conv_start && cfg_rdata[0] && $past(cfg_rdata[0])) |-> ref_en);

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && conv_start) |=> !conv_start);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && conv_start) |-> busy);

  assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !busy && conv_done && !conv_req) |=> !busy);

endmodule

bind refpwr_sequencer refpwr_checker u_refpwr_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_rdata  (cfg_rdata),
  .conv_req   (conv_req),
  .conv_done  (conv_done),
  .ref_en     (ref_en),
  .conv_start (conv_start),
  .busy       (busy)
);

// File: tb/refpwr_sequencer_test.sv
module refpwr_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int D1 = 3;
  localparam int D2 = 5;
  localparam int D3 = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic       conv_req = 1'b0;
  logic       conv_done = 1'b0;
  logic       ref_en, ref_vsel, conv_start, busy;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refpwr_sequencer #(
    .CLKS_PER_US (CPU),
    .DLY1_US     (D1),
    .DLY2_US     (D2),
    .DLY3_US     (D3)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .ref_en     (ref_en),
    .ref_vsel   (ref_vsel),
    .conv_start (conv_start),
    .busy       (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wait_us(input int code);
    case (code)
      1:       return D1;
      2:       return D2;
      3:       return D3;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 6'b000010, "R1 reset value", cfg_rdata, 2);
    chk(!ref_en, "R2 reset ref_en", ref_en, 0);
    chk(!busy && !conv_start, "R7 reset idle", {busy, conv_start}, 0);
    chk(!ref_vsel, "R9 reset vsel", ref_vsel, 0);

    for (int c = 0; c < 32; c++) begin
      bit intm, pdn, vsel;
      int code, exp_w, n, base_en;
      intm  = c[0];
      pdn   = c[1];
      vsel  = c[2];
      code  = (c >> 3) & 3;
      exp_w = (intm && pdn) ? wait_us(code) * CPU : 0;
      base_en = (intm && !pdn) ? 1 : 0;

      cfg_we    = 1'b1;
      cfg_wdata = {c[0], c[4:0]};
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (2) @(negedge clk);
      chk(cfg_rdata == 6'(c), "R1 readback", cfg_rdata, c);
      chk(ref_vsel == vsel, "R9 vsel", ref_vsel, vsel);
      chk(ref_en == base_en, intm ? "R3 idle ref_en" : "R2 idle ref_en", ref_en, base_en);

      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      n = 0;
      chk(busy, "R7 busy after request", busy, 1);
      chk(ref_en == intm, intm ? "R4 ref_en after request" : "R2 ref_en after request", ref_en, intm);
      while (!conv_start && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk(n == exp_w, (intm && pdn) ? "R5 settling wait" : "R6 immediate start", n, exp_w);
      chk(ref_en == intm, intm ? "R4 ref_en at start" : "R2 ref_en at start", ref_en, intm);

      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      chk(!conv_start, "R7 start one cycle", conv_start, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!conv_start && busy, "R8 request while busy", {busy, conv_start}, 2);
      end

      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk(!busy, "R7 busy clears after done", busy, 0);
      chk(ref_en == base_en, (intm && pdn) ? "R4 ref_en drops after done" : "R3 ref_en after done", ref_en, base_en);

      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      @(negedge clk);
      chk(!busy && !conv_start, "R8 done while idle", {busy, conv_start}, 0);
      chk(ref_en == base_en, "R8 ref_en after idle done", ref_en, base_en);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule